// File: doc/BRIEF.md
# Jack Detect Output Enable Controller

This block switches a group of six audio output enables according to whether a jack is plugged in. One of five external detect pins is chosen by a source select field. The chosen pin is brought into the system clock domain, can be inverted, and is then debounced against a timeout tick. The debounced level picks one of two programmed 6-bit masks. That mask is ANDed with the normal per-output enables, so a mask can only remove an enable and never add one.

The usual setup mutes the line outputs and turns on the headphone driver and charge pump when a plug is present. An output that must not react to the jack has its bit set in both masks. When the global detect enable is clear, every output follows its normal enable alone. The debounced level is also brought out on a pin of its own so that a general-purpose output can carry it.

The configuration arrives as one packed word. From bit 0 upward it holds: mask for detect state 0 [5:0], mask for detect state 1 [11:6], source select [14:12], invert [15], detect enable [16], tick enable [17], slow tick select [18].

Top module: `jdo_ctrl`

## Requirements
- R1: After reset the debounced detect level is 0 and, with the configuration word all zero, each output enable equals its normal enable.
- R2: While the detect enable (config bit 16) is 0, each output enable equals its normal enable whatever the debounced detect level.
- R3: Source select codes 0 to 4 (config bits [14:12]) choose detect pin 0 to 4 respectively, and the other pins have no effect.
- R4: Source select codes 5, 6 and 7 give a constant 0 detect input, so the state-0 mask applies however the pins are driven.
- R5: With the invert bit (config bit 15) set, a low level on the selected pin gives debounced detect level 1, and a high level gives 0.
- R6: While detection is enabled, output bit i equals normal enable bit i AND bit i of the state-0 mask (config [5:0]) when the detect level is 0, or of the state-1 mask (config [11:6]) when it is 1. Bits 0 to 5 are line-out 1 left, line-out 1 right, line-out 2 left, line-out 2 right, headphone driver and charge pump.
- R7: An output whose normal enable is 0 is 0 in every detect state.
- R8: An output whose bit is set in both masks equals its normal enable across every change of detect level.
- R9: The debounced level takes a new value only after the synchronized, polarity-corrected input has differed from it on two consecutive timeout ticks. A return to the current level between those ticks restarts the count.
- R10: The debounced level does not change while the tick enable (config bit 17) is 0. The slow tick select (config bit 18) picks the slow tick input when 1 and the fast tick input when 0, and the tick input that is not picked is ignored.
- R11: The debounced detect level appears on det_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 19 | Packed configuration word, layout given above |
| pins_i | input | 5 | Raw detect pins, asynchronous |
| out_req_i | input | 6 | Normal per-output enables |
| tick_fast_i | input | 1 | Fast timeout tick, one clock wide |
| tick_slow_i | input | 1 | Slow timeout tick, one clock wide |
| out_en_o | output | 6 | Final output enables |
| det_o | output | 1 | Debounced detect level |

## Verification
On every cycle the assertions check three things. An output never rises above its normal enable. Outputs track their normal enables exactly while detection is off or while their bit is set in both masks. The debounced level holds still in any cycle that follows one with no selected tick, or one with the tick enable clear. Only the bench's scenarios can show which pin each source code picks, that reserved codes read as 0, that inversion works and that the right mask bit reaches each output. They also show that the level needs two consecutive ticks and that a glitch between ticks restarts the count.

// File: rtl/jdo_pkg.sv
package jdo_pkg;
   // Output positions inside every 6-bit mask and enable vector
   localparam int unsigned OUT_LO1_L = 0;
   localparam int unsigned OUT_LO1_R = 1;
   localparam int unsigned OUT_LO2_L = 2;
   localparam int unsigned OUT_LO2_R = 3;
   localparam int unsigned OUT_HP    = 4;
   localparam int unsigned OUT_CPUMP = 5;
   localparam int unsigned OUT_COUNT = 6;

   // Width of a counter able to hold values 0 .. n-1
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/jdo_src_mux.sv
module jdo_src_mux #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned SEL_W   = 3
) (
   input  logic [NUM_SRC-1:0] pins_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic               pin_o
);
   // Codes at or above NUM_SRC match no pin and read as 0
   always_comb begin
      pin_o = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel_i == SEL_W'(i)) pin_o = pins_i[i];
      end
   end
endmodule

// File: rtl/jdo_sync.sv
module jdo_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else if (STAGES == 1) chain_q <= d_i;
            else chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/jdo_debounce.sv
module jdo_debounce #(
   parameter int unsigned HOLD_TICKS = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sample_i,
   input  logic tick_i,
   output logic state_o
);
   localparam int unsigned CNT_W = jdo_pkg::cnt_width(HOLD_TICKS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

   logic             state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= 1'b0;
         cnt_q   <= '0;
      end else if (sample_i == state_q) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (cnt_q == LAST) begin
            state_q <= sample_i;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/jdo_gate.sv
module jdo_gate #(
   parameter int unsigned NUM_OUT = 6
) (
   input  logic               jd_ena_i,
   input  logic               det_i,
   input  logic [NUM_OUT-1:0] mask0_i,
   input  logic [NUM_OUT-1:0] mask1_i,
   input  logic [NUM_OUT-1:0] req_i,
   output logic [NUM_OUT-1:0] en_o
);
   generate
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
         logic keep;
         assign keep    = det_i ? mask1_i[i] : mask0_i[i];
         assign en_o[i] = req_i[i] & (~jd_ena_i | keep);
      end
   endgenerate
endmodule

// File: rtl/jdo_ctrl.sv
module jdo_ctrl #(
   parameter int unsigned NUM_SRC     = 5,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned NUM_OUT     = jdo_pkg::OUT_COUNT,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_TICKS  = 2,
   localparam int unsigned CFG_W      = 2 * NUM_OUT + SEL_W + 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [CFG_W-1:0]   cfg_i,
   input  logic [NUM_SRC-1:0] pins_i,
   input  logic [NUM_OUT-1:0] out_req_i,
   input  logic               tick_fast_i,
   input  logic               tick_slow_i,
   output logic [NUM_OUT-1:0] out_en_o,
   output logic               det_o
);
   localparam int unsigned M1_LSB  = NUM_OUT;
   localparam int unsigned SEL_LSB = 2 * NUM_OUT;
   localparam int unsigned INV_BIT = SEL_LSB + SEL_W;
   localparam int unsigned ENA_BIT = INV_BIT + 1;
   localparam int unsigned TKE_BIT = INV_BIT + 2;
   localparam int unsigned TKS_BIT = INV_BIT + 3;

   generate
      if (NUM_SRC < 1 || NUM_SRC > (1 << SEL_W)) begin : g_bad_src
         $error("jdo_ctrl: NUM_SRC must lie in 1 .. 2**SEL_W");
      end
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("jdo_ctrl: HOLD_TICKS must be at least 1");
      end
      if (NUM_OUT < 1) begin : g_bad_out
         $error("jdo_ctrl: NUM_OUT must be at least 1");
      end
   endgenerate

   logic [NUM_OUT-1:0] mask0, mask1;
   logic [SEL_W-1:0]   src_sel;
   logic               invert, jd_ena, tick_ena, tick_slow_sel;
   logic               raw_pin, sync_pin, tick_sel;

   assign mask0         = cfg_i[NUM_OUT-1:0];
   assign mask1         = cfg_i[M1_LSB +: NUM_OUT];
   assign src_sel       = cfg_i[SEL_LSB +: SEL_W];
   assign invert        = cfg_i[INV_BIT];
   assign jd_ena        = cfg_i[ENA_BIT];
   assign tick_ena      = cfg_i[TKE_BIT];
   assign tick_slow_sel = cfg_i[TKS_BIT];

   assign tick_sel = tick_ena & (tick_slow_sel ? tick_slow_i : tick_fast_i);

   jdo_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
      .pins_i (pins_i),
      .sel_i  (src_sel),
      .pin_o  (raw_pin)
   );

   jdo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_pin),
      .q_o    (sync_pin)
   );

   jdo_debounce #(.HOLD_TICKS(HOLD_TICKS)) u_deb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (sync_pin ^ invert),
      .tick_i   (tick_sel),
      .state_o  (det_o)
   );

   jdo_gate #(.NUM_OUT(NUM_OUT)) u_gate (
      .jd_ena_i (jd_ena),
      .det_i    (det_o),
      .mask0_i  (mask0),
      .mask1_i  (mask1),
      .req_i    (out_req_i),
      .en_o     (out_en_o)
   );
endmodule

// File: rtl/jdo_ctrl_chk.sv
module jdo_ctrl_chk #(
   parameter int unsigned NUM_OUT = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_OUT-1:0] req,
   input logic [NUM_OUT-1:0] out,
   input logic               det,
   input logic [NUM_OUT-1:0] mask0,
   input logic [NUM_OUT-1:0] mask1,
   input logic               jd_ena,
   input logic               tick_ena,
   input logic               tick_sel
);
   // R7
   out_within_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out & ~req) == '0);

   // R2
   off_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !jd_ena |-> out == req);

   // R8
   both_masks_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((out ^ req) & mask0 & mask1) == '0);

   // R9
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_sel |=> $stable(det));

   // R10
   tick_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_ena |=> $stable(det));
endmodule

bind jdo_ctrl jdo_ctrl_chk #(.NUM_OUT(NUM_OUT)) u_chk (
   .clk      (clk_i),
   .rst_n    (rst_ni),
   .req      (out_req_i),
   .out      (out_en_o),
   .det      (det_o),
   .mask0    (mask0),
   .mask1    (mask1),
   .jd_ena   (jd_ena),
   .tick_ena (tick_ena),
   .tick_sel (tick_sel)
);

// File: tb/sim_jdo_ctrl.sv
`timescale 1ns/1ps
module sim_jdo_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [18:0] cfg;
   logic [4:0]  pins = '0;
   logic [5:0]  req = '0;
   logic        tf = 1'b0, ts = 1'b0;
   logic [5:0]  out_en;
   logic        det;

   logic [5:0] m0 = '0, m1 = '0;
   logic [2:0] sel = '0;
   logic       inv = 0, ena = 0, tke = 0, tks = 0;

   assign cfg = {tks, tke, ena, inv, sel, m1, m0};

   int checks = 0, fails = 0;
   logic [5:0] q_out[$];
   logic       q_det[$];
   string      q_tag[$];
   bit         done = 0;

   always #5 clk = ~clk;

   jdo_ctrl u0 (
      .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .pins_i(pins),
      .out_req_i(req), .tick_fast_i(tf), .tick_slow_i(ts),
      .out_en_o(out_en), .det_o(det)
   );

   // monitor: compares queued expectations at the falling edge
   always @(negedge clk) begin
      while (q_out.size() > 0) begin
         logic [5:0] eo;
         logic       ed;
         string      t;
         eo = q_out.pop_front();
         ed = q_det.pop_front();
         t  = q_tag.pop_front();
         checks++;
         if (out_en !== eo || det !== ed) begin
            fails++;
            $display("FAIL %s: out=%b det=%b expected out=%b det=%b",
                     t, out_en, det, eo, ed);
         end
      end
   end

   task automatic expect_now(input string t, input logic [5:0] eo, input logic ed);
      q_out.push_back(eo);
      q_det.push_back(ed);
      q_tag.push_back(t);
      @(negedge clk);
      #1;
   endtask

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   // one-cycle pulse on fast (s=0) or slow (s=1) tick
   task automatic pulse(input bit s);
      @(posedge clk); #2;
      if (s) ts = 1; else tf = 1;
      @(posedge clk); #2;
      ts = 0; tf = 0;
   endtask

   // let the synchronizer settle, then two ticks of the chosen rate
   task automatic settle_deb(input bit s);
      step(3);
      pulse(s);
      step(1);
      pulse(s);
   endtask

   initial begin
      #1;
      req = 6'b101101;
      step(3);
      rst_n = 1;
      expect_now("R1 reset", 6'b101101, 1'b0);

      // R2 and R11: detection off, det tracks pin 0, outputs follow req
      tke = 1; req = 6'h3F; m0 = 6'h00; m1 = 6'h00;
      pins = 5'b00001;
      settle_deb(0);
      expect_now("R2 off with det=1", 6'h3F, 1'b1);
      expect_now("R11 det_o high", 6'h3F, 1'b1);

      // R6: masks per state
      ena = 1; m0 = 6'b000011; m1 = 6'b110100;
      step(1);
      expect_now("R6 state1 mask", 6'b110100, 1'b1);
      pins = 5'b00000;
      settle_deb(0);
      expect_now("R6 state0 mask", 6'b000011, 1'b0);
      m0 = 6'b101010; step(1);
      expect_now("R6 bit map", 6'b101010, 1'b0);

      // R7: normal enable off stays off
      m0 = 6'h3F; m1 = 6'h3F; req = 6'b001111; step(1);
      expect_now("R7 req gates state0", 6'b001111, 1'b0);
      pins = 5'b00001; settle_deb(0);
      expect_now("R7 req gates state1", 6'b001111, 1'b1);

      // R8: headphone bit in both masks
      req = 6'h3F; m0 = 6'b010001; m1 = 6'b010010; step(1);
      expect_now("R8 state1", 6'b010010, 1'b1);
      pins = 5'b00000; settle_deb(0);
      expect_now("R8 state0", 6'b010001, 1'b0);

      // R3: each code picks its own pin only
      m0 = 6'b000001; m1 = 6'b000010;
      for (int k = 0; k < 5; k++) begin
         sel = 3'(k);
         pins = 5'(1 << k); settle_deb(0);
         expect_now($sformatf("R3 code %0d pin high", k), 6'b000010, 1'b1);
         pins = ~5'(1 << k); settle_deb(0);
         expect_now($sformatf("R3 code %0d others high", k), 6'b000001, 1'b0);
      end

      // R4: reserved codes read as 0
      for (int k = 5; k < 8; k++) begin
         sel = 3'(k); pins = 5'b11111; settle_deb(0);
         expect_now($sformatf("R4 code %0d", k), 6'b000001, 1'b0);
      end

      // R5: inversion
      sel = 0; inv = 1; pins = 5'b00000; settle_deb(0);
      expect_now("R5 low pin gives 1", 6'b000010, 1'b1);
      pins = 5'b00001; settle_deb(0);
      expect_now("R5 high pin gives 0", 6'b000001, 1'b0);
      inv = 0;

      // R9: one tick is not enough; glitch restarts count
      pins = 5'b00001; step(3); pulse(0); step(2);
      expect_now("R9 one tick", 6'b000001, 1'b0);
      pulse(0);
      expect_now("R9 two ticks", 6'b000010, 1'b1);
      pins = 5'b00000; step(3); pulse(0);
      pins = 5'b00001; step(3);
      pins = 5'b00000; step(3); pulse(0); step(1);
      expect_now("R9 glitch restarts", 6'b000010, 1'b1);
      pulse(0);
      expect_now("R9 after restart", 6'b000001, 1'b0);

      // R10: tick enable off, then slow rate select
      tke = 0; pins = 5'b00001; settle_deb(0); pulse(1); pulse(1);
      expect_now("R10 tick disabled", 6'b000001, 1'b0);
      tke = 1; tks = 1; step(1);
      pulse(0); step(1); pulse(0); step(1);
      expect_now("R10 fast ignored when slow", 6'b000001, 1'b0);
      pulse(1); step(1); pulse(1);
      expect_now("R10 slow tick used", 6'b000010, 1'b1);

      step(2);
      done = 1;
   end

   initial begin
      int n = 0;
      while (!done && n < 20000) begin @(posedge clk); n++; end
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule